// File: doc/BRIEF.md
# Black Level Calibration Controller

This block closes the digital side of a black level offset loop in an image sensor digitizer. On every line it ignores a programmable number of valid pixels after the line-start pulse, then sums a power-of-two count of optical-black samples from the 12-bit converter stream. It divides the sum by that count with a shift and compares the result with a target black level. It then moves a pair of offset DAC accumulators, fine and coarse, by one step in the direction that reduces the error.

A 10-bit control word selects the averaging length and the step size, and carries a freeze flag and a manual override flag. The fine accumulator does the tracking. When it runs out of range it returns to mid-scale and the coarse accumulator takes one step. Under manual override the two DAC outputs show externally supplied codes, while the loop keeps running underneath.

Top module: `blk_cal_ctrl`

## Requirements
- R1: The sample count is 4 shifted left by the code in control bits 9..7 (4 to 512), latched at line start. The average is the sum shifted right by 2 plus the code, truncated.
- R2: After line start, the first `wait_cnt` valid pixels are skipped. Averaging starts with the next valid pixel, so a value of 0 skips nothing.
- R3: While control bit 1 (freeze) is 1, neither accumulator changes.
- R4: While control bit 0 (manual) is 1, `coarse_code` and `fine_code` equal `man_coarse` and `man_fine`. The accumulators keep updating and appear again when the bit returns to 0.
- R5: When an average completes, the fine accumulator falls by one step if the average is above `target` and rises by one step if it is below; it is unchanged if they are equal. The step is 1, or FAST_STEP (4) while control bit 2 is 1. The new value is visible after the clock edge that takes the last sample.
- R6: If a fine step would leave 0..255, the fine accumulator returns to 128 and the coarse accumulator moves by one in the same direction. If the coarse accumulator is already at 0 or 255, the fine accumulator clamps at its end instead.
- R7: If a line ends before its average completes, both accumulators stay unchanged. This covers a wait longer than the line and a count longer than the line. A new line start discards any partial sum.
- R8: Cycles with `pix_vld` low are neither skipped nor summed, and they never change the accumulators.
- R9: After reset, both accumulators are 128. Control bits 6..3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_data | input | 12 | Converter sample |
| pix_vld | input | 1 | Sample valid strobe |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| ctrl_word | input | 10 | Calibration control word |
| wait_cnt | input | 12 | Valid pixels to skip after line start |
| target | input | 12 | Desired black level |
| man_coarse | input | 8 | Manual coarse DAC code |
| man_fine | input | 8 | Manual fine DAC code |
| coarse_code | output | 8 | Coarse DAC code |
| fine_code | output | 8 | Fine DAC code |

## Verification
The hardest state to reach is the coarse accumulator at its lower limit, where a further fine underflow must clamp rather than re-centre. Every coarse step costs about 33 fast-step lines of 4 pixels. The bench therefore drives more than four thousand short lines with a high black level, and compares each against a step model after every line. It then reverses the error to watch the fine accumulator climb out and carry into the coarse one.

// File: rtl/blk_cal_ctrl.sv
module blk_cal_ctrl #(
  parameter int DW = 12,
  parameter int CW = 8,
  parameter int FW = 8,
  parameter int WW = 12,
  parameter int FAST_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_vld,
  input  logic          line_start,
  input  logic [9:0]    ctrl_word,
  input  logic [WW-1:0] wait_cnt,
  input  logic [DW-1:0] target,
  input  logic [CW-1:0] man_coarse,
  input  logic [FW-1:0] man_fine,
  output logic [CW-1:0] coarse_code,
  output logic [FW-1:0] fine_code
);
  localparam int CNT_W = 10;
  localparam int SUM_W = DW + 9;
  localparam logic [FW-1:0] FMID = FW'(1) << (FW - 1);
  localparam logic [FW-1:0] FMAX = '1;
  localparam logic [CW-1:0] CMID = CW'(1) << (CW - 1);
  localparam logic [CW-1:0] CMAX = '1;

  logic             active;
  logic [2:0]       code_q;
  logic [WW-1:0]    skip_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q;
  logic [FW-1:0]    fine_q, fine_nxt;
  logic [CW-1:0]    coarse_q, coarse_nxt;

  wire              hold     = ctrl_word[1];
  wire              manual   = ctrl_word[0];
  wire [FW-1:0]     step     = ctrl_word[2] ? FW'(FAST_STEP) : FW'(1);
  wire              in_line  = active && pix_vld && !line_start;
  wire              skipping = skip_q < wait_cnt;
  wire              last     = cnt_q == ((CNT_W'(4) << code_q) - CNT_W'(1));
  wire              take     = in_line && !skipping;
  wire [SUM_W-1:0]  new_sum  = sum_q + SUM_W'(pix_data);
  wire [DW-1:0]     avg      = DW'(new_sum >> (5'(code_q) + 5'd2));
  wire              upd      = take && last && !hold;

  always_comb begin
    fine_nxt   = fine_q;
    coarse_nxt = coarse_q;
    if (avg < target) begin
      if (fine_q > FMAX - step) begin
        if (coarse_q != CMAX) begin
          fine_nxt   = FMID;
          coarse_nxt = coarse_q + CW'(1);
        end else fine_nxt = FMAX;
      end else fine_nxt = fine_q + step;
    end else if (avg > target) begin
      if (fine_q < step) begin
        if (coarse_q != '0) begin
          fine_nxt   = FMID;
          coarse_nxt = coarse_q - CW'(1);
        end else fine_nxt = '0;
      end else fine_nxt = fine_q - step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      code_q   <= 3'b101;
      skip_q   <= '0;
      cnt_q    <= '0;
      sum_q    <= '0;
      fine_q   <= FMID;
      coarse_q <= CMID;
    end else begin
      if (line_start) begin
        active <= 1'b1;
        code_q <= ctrl_word[9:7];
        skip_q <= '0;
        cnt_q  <= '0;
        sum_q  <= '0;
      end else if (in_line) begin
        if (skipping) skip_q <= skip_q + WW'(1);
        else if (last) active <= 1'b0;
        else begin
          cnt_q <= cnt_q + CNT_W'(1);
          sum_q <= new_sum;
        end
      end
      if (upd) begin
        fine_q   <= fine_nxt;
        coarse_q <= coarse_nxt;
      end
    end
  end

  assign coarse_code = manual ? man_coarse : coarse_q;
  assign fine_code   = manual ? man_fine   : fine_q;

  assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(fine_q) && $stable(coarse_q)));

  assert_no_update_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> ($stable(fine_q) && $stable(coarse_q)));

  assert_coarse_recentre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coarse_q) |-> fine_q == FMID);

  assert_coarse_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (coarse_q == $past(coarse_q) || coarse_q == $past(coarse_q) + CW'(1)
              || coarse_q == $past(coarse_q) - CW'(1)));
endmodule

// File: tb/blk_cal_ctrl_tb_top.sv
module blk_cal_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic [11:0] pix_data = 0, wait_cnt = 0, target = 0;
  logic pix_vld = 0, line_start = 0;
  logic [9:0] ctrl_word = 0;
  logic [7:0] man_coarse = 0, man_fine = 0, coarse_code, fine_code;
  int checks = 0, fails = 0, exp_f = 128, exp_c = 128, ticks = 0;

  always #2 clk = ~clk;

  blk_cal_ctrl dut_i (.clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_vld(pix_vld),
    .line_start(line_start), .ctrl_word(ctrl_word), .wait_cnt(wait_cnt), .target(target),
    .man_coarse(man_coarse), .man_fine(man_fine), .coarse_code(coarse_code), .fine_code(fine_code));

  typedef struct packed {
    logic [2:0] code; logic [11:0] wt; logic [11:0] len; logic [11:0] val;
    logic [11:0] tgt; logic fast; logic alt; logic gap; logic [7:0] fine; logic [7:0] coarse;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{3'd0, 12'd1,  12'd8,   12'd100,  12'd64,   1'b0, 1'b0, 1'b0, 8'd127, 8'd128},
    '{3'd2, 12'd3,  12'd20,  12'd10,   12'd64,   1'b0, 1'b0, 1'b0, 8'd128, 8'd128},
    '{3'd1, 12'd0,  12'd8,   12'd64,   12'd64,   1'b0, 1'b1, 1'b0, 8'd128, 8'd128},
    '{3'd0, 12'd1,  12'd8,   12'd200,  12'd64,   1'b1, 1'b0, 1'b0, 8'd124, 8'd128},
    '{3'd3, 12'd0,  12'd20,  12'd0,    12'd64,   1'b0, 1'b0, 1'b0, 8'd124, 8'd128},
    '{3'd0, 12'd25, 12'd20,  12'd0,    12'd64,   1'b0, 1'b0, 1'b0, 8'd124, 8'd128},
    '{3'd0, 12'd2,  12'd8,   12'd0,    12'd64,   1'b0, 1'b0, 1'b1, 8'd125, 8'd128},
    '{3'd1, 12'd0,  12'd10,  12'd63,   12'd64,   1'b0, 1'b1, 1'b0, 8'd126, 8'd128},
    '{3'd7, 12'd0,  12'd512, 12'd4095, 12'd4094, 1'b0, 1'b0, 1'b0, 8'd125, 8'd128}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_line(input int len, input int val, input bit alt, input bit gap);
    @(negedge clk); line_start = 1; pix_vld = 0;
    @(negedge clk); line_start = 0;
    for (int i = 0; i < len; i++) begin
      pix_vld = 1; pix_data = 12'(val + (alt ? (i & 1) : 0));
      @(negedge clk);
      if (gap) begin pix_vld = 0; pix_data = 12'hFFF; @(negedge clk); end
    end
    pix_vld = 0; pix_data = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic model(input bit down, input bit fast);
    int st = fast ? 4 : 1;
    if (down) begin
      if (exp_f < st) begin if (exp_c != 0) begin exp_f = 128; exp_c--; end else exp_f = 0; end
      else exp_f -= st;
    end else begin
      if (exp_f > 255 - st) begin if (exp_c != 255) begin exp_f = 128; exp_c++; end else exp_f = 255; end
      else exp_f += st;
    end
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", ticks, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset fine", fine_code, 128);
    check("R9 reset coarse", coarse_code, 128);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 9; k++) begin
      ctrl_word = {VEC[k].code, (k % 2 == 1) ? 4'hF : 4'h0, VEC[k].fast, 2'b00};
      wait_cnt = VEC[k].wt; target = VEC[k].tgt;
      run_line(int'(VEC[k].len), int'(VEC[k].val), VEC[k].alt, VEC[k].gap);
      check($sformatf("R1 R2 R5 R7 R8 R9 vec%0d fine", k), fine_code, int'(VEC[k].fine));
      check($sformatf("R6 vec%0d coarse", k), coarse_code, int'(VEC[k].coarse));
    end
    exp_f = 125; exp_c = 128;

    ctrl_word = {3'd0, 4'h0, 3'b110}; wait_cnt = 0; target = 64;
    run_line(4, 200, 0, 0);
    check("R3 freeze fine", fine_code, exp_f);
    check("R3 freeze coarse", coarse_code, exp_c);

    ctrl_word = {3'd0, 4'h0, 3'b001}; man_coarse = 8'h11; man_fine = 8'h22;
    @(negedge clk);
    check("R4 manual coarse", coarse_code, 8'h11);
    check("R4 manual fine", fine_code, 8'h22);
    run_line(4, 200, 0, 0);
    model(1, 0);
    check("R4 manual held during line", fine_code, 8'h22);
    ctrl_word = 10'd0;
    @(negedge clk);
    check("R4 loop ran under manual", fine_code, exp_f);
    check("R4 coarse back", coarse_code, exp_c);

    ctrl_word = {3'd0, 4'h0, 3'b100}; target = 64;
    for (int n = 0; n < 4300; n++) begin
      run_line(4, 200, 0, 0);
      model(1, 1);
      check("R6 down fine", fine_code, exp_f);
      check("R6 down coarse", coarse_code, exp_c);
    end
    check("R6 clamp fine at 0", fine_code, 0);
    check("R6 clamp coarse at 0", coarse_code, 0);

    for (int n = 0; n < 70; n++) begin
      run_line(4, 0, 0, 0);
      model(0, 1);
      check("R6 up fine", fine_code, exp_f);
      check("R6 up coarse", coarse_code, exp_c);
    end
    check("R6 carried into coarse", coarse_code, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule